// File: doc/BRIEF.md
# Guarded EEPROM Program and Erase Sequencer

This block fronts a byte-wide non-volatile array with a guarded write procedure. Software first sets a latch-enable bit in a five-bit control register. It then writes one address and data pair, either through the array window or through a port that reaches a hidden configuration byte stored just past the last array location. Next it raises a voltage-enable bit, holds it for a minimum number of clock cycles, and drops it again. The falling edge of that bit commits one operation. The operation is either a program that can only clear bits, or an erase of one byte, of an aligned group of sixteen bytes, or of the whole storage.

The hidden configuration byte is copied into a live configuration register only at reset. Bit 0 of that live register opens the array window to the bus. Every request is accepted in the cycle it is presented, so the bus has no back-pressure. Read data returns one cycle after the request, with `rd_valid`. Any violation of the procedure produces a one-cycle error pulse and a code that names the broken rule.

Top module: `eeprom_seq`

## Requirements
- R1: A control write that sets latch-enable (bit 1) and voltage-enable (bit 0) together, when both were clear, reports code 1 and leaves the control register unchanged.
- R2: Any control write with bit 1 at 0 clears the whole control register to zero, raises no error and drops any captured pair. Clearing both bits in one write is legal.
- R3: Raising bit 0 while bit 1 was not already set, or while no pair is captured, reports code 2.
- R4: While bit 1 is set, the first write to the array window (space 0) or the configuration port (space 2) captures address and data, and the array does not change. A second such write before the commit reports code 3. Such a write while bit 1 is clear reports code 4.
- R5: An array read while bit 1 is set reports code 5 (the data is still returned). The control register (space 1) and the live configuration (space 2) can always be read.
- R6: The hold time is the number of cycles from the write that raises bit 0 to the write that drops it. A hold shorter than MIN_HOLD reports code 6, and the operation still executes. A hold of exactly MIN_HOLD is accepted.
- R7: With the erase bit (bit 2) at 0, the commit sets the target to its old value AND the captured byte.
- R8: With bit 2 at 1 and either the byte-select bit (bit 4) set or the target being the hidden configuration byte, only the target becomes 0xFF.
- R9: With bit 2 at 1, bit 4 clear and the row-select bit (bit 3) set, the sixteen bytes of the 16-aligned group holding the target become 0xFF.
- R10: With bit 2 at 1 and bits 4 and 3 clear, every location, the hidden configuration byte included, becomes 0xFF.
- R11: A commit clears the captured pair. A multi-byte write, an access to space 3, and any array access while the window is closed report code 7.
- R12: Reset clears the control register and the captured pair and loads the live configuration from the hidden byte. Programming the hidden byte does not change the live value before the next reset. The window is open only when live bit 0 is 1, and a closed window reads as 0xFF.
- R13: `err_pulse` is high for exactly the cycle after an offending request, and `err_code` is 0 whenever it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Space: 0 array, 1 control, 2 configuration, 3 unused |
| bus_addr | input | AW | Array byte address |
| bus_wide | input | 1 | Write wider than one byte |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Violated rule code |

## Verification
The bench walks the rule set around the control register: a simultaneous rise of both bits, voltage without a captured pair, a double capture, and a read under latch. A design that compared old and new bit values wrongly would either block the legal latch-then-voltage step or accept the forbidden one. The hold window is probed at exactly MIN_HOLD and at one cycle less, which exposes an off-by-one in the cycle counter. Row erase is checked on both sides of a 16-byte boundary, and bulk erase is checked against the hidden byte across a reset. A design that erased the wrong group, spared the hidden byte, or updated the live configuration too early would return wrong read data.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_BOTH    = 3'd1,
    E_HV      = 3'd2,
    E_DUP     = 3'd3,
    E_NOLATCH = 3'd4,
    E_RDLATCH = 3'd5,
    E_SHORT   = 3'd6,
    E_ACCESS  = 3'd7
  } err_e;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_BYTE,
    OP_ROW,
    OP_BULK
  } op_e;

  localparam int B_SEL_BYTE = 4;
  localparam int B_SEL_ROW  = 3;
  localparam int B_ERASE    = 2;
  localparam int B_LATCH    = 1;
  localparam int B_HV       = 0;

  localparam logic [1:0] SP_ARRAY = 2'd0;
  localparam logic [1:0] SP_CTL   = 2'd1;
  localparam logic [1:0] SP_CFG   = 2'd2;

  localparam int ROW_SHIFT = 4;

endpackage

// File: rtl/eeprom_seq_hold_timer.sv
module eeprom_seq_hold_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (start)
      count <= CW'(1);
    else if (run && (count != '1))
      count <= count + 1'b1;
  end

endmodule

// File: rtl/eeprom_seq_store.sv
module eeprom_seq_store
  import eeprom_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          commit,
  input  op_e           op,
  input  logic [IW-1:0] tgt,
  input  logic [7:0]    wbyte,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [7:0]    hidden_byte
);

  localparam int CELLS = DEPTH + 1;

  logic [7:0] mem [CELLS] = '{default: 8'hFF};

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < CELLS; i++) begin
        case (op)
          OP_PROG: if (IW'(i) == tgt) mem[i] <= mem[i] & wbyte;
          OP_BYTE: if (IW'(i) == tgt) mem[i] <= 8'hFF;
          OP_ROW:  if ((IW'(i) >> ROW_SHIFT) == (tgt >> ROW_SHIFT)) mem[i] <= 8'hFF;
          default: mem[i] <= 8'hFF;
        endcase
      end
    end
  end

  assign rd_byte     = mem[rd_idx];
  assign hidden_byte = mem[DEPTH];

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MIN_HOLD = 10000,
  parameter int CW       = 32,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wide,
  input  logic [7:0]    bus_wdata,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          err_pulse,
  output logic [2:0]    err_code
);

  localparam int IW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] CFG_IDX = IW'(DEPTH);

  logic [4:0]    ctl_q;
  logic [7:0]    cfg_q;
  logic          pend_q;
  logic [IW-1:0] tgt_q;
  logic [7:0]    byte_q;
  logic [CW-1:0] hold_cnt;
  logic [7:0]    rd_byte, hidden_byte;

  logic       wr, rd, win, both_rise, ctl_wr, data_wr, hv_rise, hv_fall, commit;
  logic [4:0] ctl_new, ctl_eff;
  err_e       err_n;
  op_e        op;

  always_comb begin
    wr        = bus_req && bus_we;
    rd        = bus_req && !bus_we;
    win       = cfg_q[0];
    ctl_new   = bus_wdata[4:0];
    both_rise = (((ctl_q ^ ctl_new) & ctl_new) & 5'b00011) == 5'b00011;
    ctl_eff   = ctl_new[B_LATCH] ? ctl_new : 5'b0;
    ctl_wr    = wr && !bus_wide && (bus_sel == SP_CTL);
    data_wr   = wr && !bus_wide &&
                ((bus_sel == SP_CFG) || ((bus_sel == SP_ARRAY) && win));
    hv_rise   = ctl_eff[B_HV] && !ctl_q[B_HV];
    hv_fall   = !ctl_eff[B_HV] && ctl_q[B_HV];
    commit    = ctl_wr && !both_rise && hv_fall && pend_q;

    err_n = E_NONE;
    if (wr && bus_wide)
      err_n = E_ACCESS;
    else if (bus_req && (bus_sel == 2'd3))
      err_n = E_ACCESS;
    else if (bus_req && (bus_sel == SP_ARRAY) && !win)
      err_n = E_ACCESS;
    else if (ctl_wr) begin
      if (both_rise)
        err_n = E_BOTH;
      else if (hv_rise && (!ctl_q[B_LATCH] || !pend_q))
        err_n = E_HV;
      else if (commit && (hold_cnt < CW'(MIN_HOLD)))
        err_n = E_SHORT;
    end
    else if (data_wr) begin
      if (!ctl_q[B_LATCH])
        err_n = E_NOLATCH;
      else if (pend_q)
        err_n = E_DUP;
    end
    else if (rd && (bus_sel == SP_ARRAY) && ctl_q[B_LATCH])
      err_n = E_RDLATCH;

    if (!ctl_q[B_ERASE])
      op = OP_PROG;
    else if (ctl_q[B_SEL_BYTE] || (tgt_q == CFG_IDX))
      op = OP_BYTE;
    else if (ctl_q[B_SEL_ROW])
      op = OP_ROW;
    else
      op = OP_BULK;
  end

  eeprom_seq_hold_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ctl_wr && !both_rise && hv_rise),
    .run   (ctl_q[B_HV]),
    .count (hold_cnt)
  );

  eeprom_seq_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
    .clk         (clk),
    .commit      (commit),
    .op          (op),
    .tgt         (tgt_q),
    .wbyte       (byte_q),
    .rd_idx      (IW'(bus_addr)),
    .rd_byte     (rd_byte),
    .hidden_byte (hidden_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      cfg_q     <= hidden_byte;
      pend_q    <= 1'b0;
      tgt_q     <= '0;
      byte_q    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      err_pulse <= 1'b0;
      err_code  <= '0;
    end else begin
      err_pulse <= (err_n != E_NONE);
      err_code  <= err_n;
      rd_valid  <= rd;
      if (rd) begin
        case (bus_sel)
          SP_CTL:   rd_data <= {3'b000, ctl_q};
          SP_CFG:   rd_data <= cfg_q;
          SP_ARRAY: rd_data <= win ? rd_byte : 8'hFF;
          default:  rd_data <= 8'hFF;
        endcase
      end
      if (ctl_wr && !both_rise) begin
        ctl_q <= ctl_eff;
        if (!ctl_eff[B_LATCH] || hv_fall)
          pend_q <= 1'b0;
      end
      if (data_wr && ctl_q[B_LATCH] && !pend_q) begin
        pend_q <= 1'b1;
        tgt_q  <= (bus_sel == SP_CFG) ? CFG_IDX : IW'(bus_addr);
        byte_q <= bus_wdata;
      end
    end
  end

endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic [1:0] bus_sel,
  input logic       bus_wide,
  input logic [1:0] wd_lo,
  input logic       err_pulse,
  input logic [2:0] err_code,
  input logic [4:0] ctl_q,
  input logic       pend_q,
  input logic       cfg_on
);

  logic ctl_w;
  assign ctl_w = bus_req && bus_we && !bus_wide && (bus_sel == 2'd1);

  // R1
  a_r1_both_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && (ctl_q[1:0] == 2'b00) && (wd_lo == 2'b11))
    |=> (err_code == 3'd1) && $stable(ctl_q));

  // R2
  a_r2_clear_on_nolatch: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !wd_lo[1]) |=> (ctl_q == 5'd0) && !pend_q);

  // R4
  a_r4_write_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_wide && (bus_sel == 2'd2) && !ctl_q[1])
    |=> err_pulse && (err_code == 3'd4));

  // R5
  a_r5_read_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && (bus_sel == 2'd0) && ctl_q[1] && cfg_on)
    |=> err_pulse && (err_code == 3'd5));

  // R11
  a_r11_pending_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && ctl_q[0] && wd_lo[1] && !wd_lo[0]) |=> !pend_q);

endmodule

bind eeprom_seq eeprom_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_sel   (bus_sel),
  .bus_wide  (bus_wide),
  .wd_lo     (bus_wdata[1:0]),
  .err_pulse (err_pulse),
  .err_code  (err_code),
  .ctl_q     (ctl_q),
  .pend_q    (pend_q),
  .cfg_on    (cfg_q[0])
);

// File: tb/test_eeprom_seq.sv
`timescale 1ns/1ps
module test_eeprom_seq;
  import eeprom_seq_pkg::*;

  localparam int DEPTH = 64;
  localparam int HOLD  = 100;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
  logic [1:0]    bus_sel = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          rd_valid, err_pulse;
  logic [7:0]    rd_data;
  logic [2:0]    err_code;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eeprom_seq #(.DEPTH(DEPTH), .MIN_HOLD(HOLD)) i_eeprom_seq (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wide(bus_wide),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_pulse(err_pulse), .err_code(err_code));

  typedef struct packed {
    logic       we;
    logic [1:0] sel;
    logic [5:0] addr;
    logic [7:0] wd;
    logic       wide;
    logic       rdv;
    logic [7:0] rd;
    logic [2:0] err;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 6'd0,  8'h00, 1'b0, 1'b1, 8'h00, 3'd0, 8'd12}, // R12 control reset value
    '{1'b0, 2'd2, 6'd0,  8'h00, 1'b0, 1'b1, 8'hFF, 3'd0, 8'd12}, // R12 live configuration
    '{1'b1, 2'd0, 6'd5,  8'h0F, 1'b0, 1'b0, 8'h00, 3'd4, 8'd4},  // R4 write with latch clear
    '{1'b1, 2'd1, 6'd0,  8'h03, 1'b0, 1'b0, 8'h00, 3'd1, 8'd1},  // R1 both rise
    '{1'b0, 2'd1, 6'd0,  8'h00, 1'b0, 1'b1, 8'h00, 3'd0, 8'd1},  // R1 unchanged
    '{1'b1, 2'd1, 6'd0,  8'h01, 1'b0, 1'b0, 8'h00, 3'd0, 8'd2},  // R2 latch 0 clears
    '{1'b0, 2'd1, 6'd0,  8'h00, 1'b0, 1'b1, 8'h00, 3'd0, 8'd2},
    '{1'b1, 2'd1, 6'd0,  8'h12, 1'b0, 1'b0, 8'h00, 3'd0, 8'd2},
    '{1'b0, 2'd1, 6'd0,  8'h00, 1'b0, 1'b1, 8'h12, 3'd0, 8'd2},
    '{1'b1, 2'd1, 6'd0,  8'h08, 1'b0, 1'b0, 8'h00, 3'd0, 8'd2},
    '{1'b0, 2'd1, 6'd0,  8'h00, 1'b0, 1'b1, 8'h00, 3'd0, 8'd2},  // R2 cleared
    '{1'b1, 2'd1, 6'd0,  8'h02, 1'b0, 1'b0, 8'h00, 3'd0, 8'd3},
    '{1'b1, 2'd1, 6'd0,  8'h03, 1'b0, 1'b0, 8'h00, 3'd2, 8'd3},  // R3 voltage without pair
    '{1'b1, 2'd1, 6'd0,  8'h00, 1'b0, 1'b0, 8'h00, 3'd0, 8'd2},  // R2 clear both legal
    '{1'b1, 2'd1, 6'd0,  8'h02, 1'b0, 1'b0, 8'h00, 3'd0, 8'd5},
    '{1'b0, 2'd0, 6'd3,  8'h00, 1'b0, 1'b1, 8'hFF, 3'd5, 8'd5},  // R5 read under latch
    '{1'b0, 2'd1, 6'd0,  8'h00, 1'b0, 1'b1, 8'h02, 3'd0, 8'd5},  // R5 control readable
    '{1'b0, 2'd2, 6'd0,  8'h00, 1'b0, 1'b1, 8'hFF, 3'd0, 8'd5},  // R5 config readable
    '{1'b1, 2'd0, 6'd10, 8'h5A, 1'b0, 1'b0, 8'h00, 3'd0, 8'd4},  // R4 capture
    '{1'b1, 2'd0, 6'd11, 8'h11, 1'b0, 1'b0, 8'h00, 3'd3, 8'd4},  // R4 second capture
    '{1'b1, 2'd2, 6'd0,  8'hAA, 1'b0, 1'b0, 8'h00, 3'd3, 8'd4},  // R4 via config port
    '{1'b1, 2'd1, 6'd0,  8'h02, 1'b1, 1'b0, 8'h00, 3'd7, 8'd11}, // R11 multi-byte write
    '{1'b1, 2'd1, 6'd0,  8'h00, 1'b0, 1'b0, 8'h00, 3'd0, 8'd2},
    '{1'b0, 2'd0, 6'd10, 8'h00, 1'b0, 1'b1, 8'hFF, 3'd0, 8'd4},  // R4 array untouched
    '{1'b0, 2'd0, 6'd11, 8'h00, 1'b0, 1'b1, 8'hFF, 3'd0, 8'd13}  // R13 pulse gone
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [1:0] sel, input logic [AW-1:0] a,
                     input logic [7:0] d, input logic wide);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_sel = sel; bus_addr = a;
    bus_wdata = d; bus_wide = wide;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [1:0] sel, input logic [AW-1:0] a,
                          input logic [7:0] exp, input logic [2:0] exp_err);
    bus(1'b0, sel, a, 8'h00, 1'b0);
    check({tag, " data"}, rd_data, exp);
    check({tag, " code"}, {5'b0, err_code}, {5'b0, exp_err});
  endtask

  // The bus task returns one half cycle after the edge that took the write,
  // so the next write lands one edge later per idle step.
  task automatic run_op(input string tag, input logic [4:0] mode, input logic [1:0] sel,
                        input logic [AW-1:0] a, input logic [7:0] d, input int k,
                        input logic [2:0] exp_err);
    bus(1'b1, SP_CTL, '0, {3'b0, mode | 5'h02}, 1'b0);
    bus(1'b1, sel, a, d, 1'b0);
    bus(1'b1, SP_CTL, '0, {3'b0, mode | 5'h03}, 1'b0);
    check({tag, " rise code"}, {5'b0, err_code}, 8'h00);
    repeat (k - 2) idle();
    bus(1'b1, SP_CTL, '0, {3'b0, mode | 5'h02}, 1'b0);
    check({tag, " commit code"}, {5'b0, err_code}, {5'b0, exp_err});
    bus(1'b1, SP_CTL, '0, 8'h00, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].we, VECS[i].sel, VECS[i].addr, VECS[i].wd, VECS[i].wide);
      check($sformatf("vec%0d R%0d code", i, VECS[i].req), {5'b0, err_code}, {5'b0, VECS[i].err});
      check($sformatf("vec%0d R%0d pulse R13", i, VECS[i].req), {7'b0, err_pulse},
            {7'b0, VECS[i].err != 3'd0});
      if (VECS[i].rdv)
        check($sformatf("vec%0d R%0d read", i, VECS[i].req), rd_data, VECS[i].rd);
    end

    // R6 exact minimum hold accepted; R7 program clears bits only
    run_op("R6 exact hold", 5'h00, SP_ARRAY, 6'd10, 8'h5A, HOLD, 3'd0);
    read_chk("R7 program", SP_ARRAY, 6'd10, 8'h5A, 3'd0);
    run_op("R7 and", 5'h00, SP_ARRAY, 6'd10, 8'h0F, HOLD, 3'd0);
    read_chk("R7 and result", SP_ARRAY, 6'd10, 8'h0A, 3'd0);

    // R11 pair released after commit: a fresh capture is accepted
    bus(1'b1, SP_CTL, '0, 8'h02, 1'b0);
    bus(1'b1, SP_ARRAY, 6'd12, 8'h00, 1'b0);
    check("R11 recapture code", {5'b0, err_code}, 8'h00);
    bus(1'b1, SP_CTL, '0, 8'h00, 1'b0);

    // R6 one cycle short: error, operation still done
    run_op("R6 short hold", 5'h00, SP_ARRAY, 6'd20, 8'hF0, HOLD - 1, 3'd6);
    read_chk("R6 executed", SP_ARRAY, 6'd20, 8'hF0, 3'd0);

    // R8 byte erase
    run_op("R8 byte erase", 5'h14, SP_ARRAY, 6'd10, 8'h00, HOLD, 3'd0);
    read_chk("R8 target", SP_ARRAY, 6'd10, 8'hFF, 3'd0);
    read_chk("R8 neighbour", SP_ARRAY, 6'd20, 8'hF0, 3'd0);

    // R9 row erase
    run_op("R9 prep a", 5'h00, SP_ARRAY, 6'd33, 8'h00, HOLD, 3'd0);
    run_op("R9 prep b", 5'h00, SP_ARRAY, 6'd47, 8'h00, HOLD, 3'd0);
    run_op("R9 prep c", 5'h00, SP_ARRAY, 6'd48, 8'h00, HOLD, 3'd0);
    run_op("R9 row erase", 5'h0C, SP_ARRAY, 6'd40, 8'h00, HOLD, 3'd0);
    read_chk("R9 row low", SP_ARRAY, 6'd33, 8'hFF, 3'd0);
    read_chk("R9 row high", SP_ARRAY, 6'd47, 8'hFF, 3'd0);
    read_chk("R9 next row", SP_ARRAY, 6'd48, 8'h00, 3'd0);
    read_chk("R9 other row", SP_ARRAY, 6'd20, 8'hF0, 3'd0);

    // R12 hidden byte programmed, live value unchanged until reset
    run_op("R12 cfg prog", 5'h00, SP_CFG, '0, 8'hFE, HOLD, 3'd0);
    read_chk("R12 live before reset", SP_CFG, '0, 8'hFF, 3'd0);

    // R10 bulk erase incl. hidden byte
    run_op("R10 bulk", 5'h04, SP_ARRAY, 6'd0, 8'h00, HOLD, 3'd0);
    read_chk("R10 cell 48", SP_ARRAY, 6'd48, 8'hFF, 3'd0);
    read_chk("R10 cell 20", SP_ARRAY, 6'd20, 8'hFF, 3'd0);
    do_reset();
    read_chk("R10 hidden erased", SP_CFG, '0, 8'hFF, 3'd0);

    // R12 reload after reset closes the window; R11 closed window access
    run_op("R12 cfg prog2", 5'h00, SP_CFG, '0, 8'hFE, HOLD, 3'd0);
    bus(1'b1, SP_CTL, '0, 8'h02, 1'b0);
    do_reset();
    read_chk("R12 live reloaded", SP_CFG, '0, 8'hFE, 3'd0);
    read_chk("R12 control cleared", SP_CTL, '0, 8'h00, 3'd0);
    read_chk("R11 window closed", SP_ARRAY, 6'd5, 8'hFF, 3'd7);

    // R8 erase aimed at hidden byte touches only it
    run_op("R8 cfg erase", 5'h04, SP_CFG, '0, 8'h00, HOLD, 3'd0);
    do_reset();
    read_chk("R8 hidden restored", SP_CFG, '0, 8'hFF, 3'd0);
    read_chk("R12 window open", SP_ARRAY, 6'd5, 8'hFF, 3'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule